// File: doc/BRIEF.md
# Bus Master Write Line Buffer

This block is the one line buffer that sits between a storage DMA engine and the system bus. It belongs to no other function. At any moment it is in one of two modes. In read mode it does not take in write data. In write mode it collects 32-bit DWords from the drive side into a line of `LINE_WORDS` entries, eight by default, which is a 32-byte cache line. It then writes the line to memory as a series of `BURST_WORDS`-beat bursts, four beats by default. Each beat carries active-low byte enables. A beat that holds no valid data goes out with every enable deasserted.

A line is flushed when it fills, or on the cycle after a word marked as last is taken in. A partial line is rounded up to whole bursts, and the positions past the last valid word are padded. The transfer can be logically complete (the active indication drops) or the device can raise its interrupt while data is still held in the line. From then until the last buffered beat has been accepted by the bus, the block tells the host target logic to retry every incoming cycle that is not a memory read.

The controller has three states. `ST_READ` is read mode. `ST_FILL` is write mode while the line is collecting data. `ST_FLUSH` is write mode while the line is being emitted. The transitions are:
- `ST_READ` moves to `ST_FILL` when write mode is requested.
- `ST_FILL` moves to `ST_FLUSH` when the word that fills the line, or a word marked last, is accepted.
- `ST_FILL` moves to `ST_READ` when read mode is requested and the line is empty.
- `ST_FLUSH` moves to `ST_FILL` when the bus accepts the final padded beat.

Top module: `bmw_line_buffer`

## Requirements
- R1: After reset the block is in read mode: `mode_wr_o`=0, `in_ready_o`=0, `bm_valid_o`=0 and `tgt_retry_o`=0.
- R2: The mode changes only while the line is empty. A change of `mode_wr_req_i` on an empty line is reflected in `mode_wr_o` one clock later. While data is buffered, `mode_wr_o` stays 1 until the flush completes.
- R3: Input words are accepted only in write mode and outside a flush (`in_ready_o`=1). At most `LINE_WORDS` words are held.
- R4: A full line is emitted as `LINE_WORDS/BURST_WORDS` bursts, with the words in arrival order and `bm_cbe_n_o`=4'h0 on every beat. `bm_first_o` marks beat 0 of each burst and `bm_last_o` marks beat `BURST_WORDS-1`.
- R5: On a last-marked word, `bm_valid_o` rises on the clock after that word is accepted. The beat count is rounded up to a multiple of `BURST_WORDS`. Pad beats carry `bm_cbe_n_o`=4'hF and zero data.
- R6: While `bm_valid_o`=1 and `bm_ready_i`=0, the beat data and enables stay stable.
- R7: If `xfer_done_i` or `dev_irq_i` is seen while data is buffered, then from the next clock a cycle with `tgt_cyc_i`=1 and `tgt_memrd_i`=0 gets `tgt_retry_o`=1. A memory read (`tgt_memrd_i`=1) is never retried.
- R8: Retry ends on the clock after the final beat of the flush is accepted. `xfer_done_i` or `dev_irq_i` on an empty line causes no retry.
- R9: After a flush completes, the line is empty and `in_ready_o` returns to 1 while write mode is still requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_req_i | input | 1 | Requested mode: 1 write, 0 read |
| mode_wr_o | output | 1 | Current mode: 1 write, 0 read |
| in_valid_i | input | 1 | Input DWord valid |
| in_data_i | input | DW | Input DWord |
| in_last_i | input | 1 | Input DWord is the last of the transfer |
| in_ready_o | output | 1 | Buffer takes the input DWord this cycle |
| bm_valid_o | output | 1 | Burst beat valid |
| bm_data_o | output | DW | Burst beat data |
| bm_cbe_n_o | output | DW/8 | Active-low byte enables of the beat |
| bm_first_o | output | 1 | First beat of a burst |
| bm_last_o | output | 1 | Last beat of a burst |
| bm_ready_i | input | 1 | Bus accepts the beat |
| xfer_done_i | input | 1 | Transfer logically complete (active indication cleared) |
| dev_irq_i | input | 1 | Device interrupt status set |
| tgt_cyc_i | input | 1 | Incoming host target cycle present |
| tgt_memrd_i | input | 1 | Incoming target cycle is a memory read |
| tgt_retry_o | output | 1 | Retry the incoming target cycle |

## Verification
The bench targets the following corner cases. Each comes with what a faulty design would do.
- **Partial line.** A five-word partial line must pad the second burst with three disabled beats. A design that stopped at the valid data would send a short burst. One that did not pad would leak stale words with their enables active.
- **Flush start.** The flush must start one clock after the last-marked word. A design that waited for a full line would hang with `bm_valid_o` low.
- **Stall.** A stalled beat must hold its value. A design that advanced the beat index without `bm_ready_i` would change the beat under the bus.
- **Retry window.** The bench opens the window with an interrupt and closes it on the final beat. A design with the clear off by one clock would still retry after the drain. One that retried memory reads, or raised retry on an empty line, would show it at `tgt_retry_o`.
- **Mode change.** A request for read mode with words buffered must be deferred. A design that switched at once would drop the held data.

// File: rtl/bmwb_pkg.sv
package bmwb_pkg;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_FILL  = 2'd1,
        ST_FLUSH = 2'd2
    } bmwb_state_e;

endpackage

// File: rtl/bmwb_store.sv
module bmwb_store #(
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8,
    localparam int IW        = $clog2(LINE_WORDS),
    localparam int CW        = $clog2(LINE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output logic [CW-1:0] cnt,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] line_q [LINE_WORDS];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            line_q[cnt_q[IW-1:0]] <= wr_data;
        end
    end

    assign cnt     = cnt_q;
    assign rd_data = line_q[rd_idx];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LINE_WORDS));

endmodule

// File: rtl/bmwb_ctrl.sv
module bmwb_ctrl
    import bmwb_pkg::*;
#(
    parameter int LINE_WORDS  = 8,
    parameter int BURST_WORDS = 4,
    localparam int IW         = $clog2(LINE_WORDS),
    localparam int CW         = $clog2(LINE_WORDS + 1),
    localparam int BW         = $clog2(BURST_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_req,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic [CW-1:0] cnt,
    input  logic          bm_ready,
    output logic          mode_wr,
    output logic          in_ready,
    output logic          wr_en,
    output logic          clr,
    output logic [IW-1:0] beat_idx,
    output logic          beat_real,
    output logic          bm_valid,
    output logic          bm_first,
    output logic          bm_last,
    output logic          drain_done
);

    bmwb_state_e   state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [CW-1:0] idx_ext;
    logic          burst_end;
    logic          final_beat;
    logic          take;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        idx_ext    = CW'(idx_q);
        burst_end  = (idx_q[BW-1:0] == {BW{1'b1}});
        final_beat = burst_end && ((idx_ext + CW'(1)) >= cnt);
        take       = (state_q == ST_FILL) && in_valid;
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_READ: begin
                if (mode_wr_req) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (take && (in_last || cnt == CW'(LINE_WORDS - 1))) begin
                    state_d = ST_FLUSH;
                    idx_d   = '0;
                end else if (!take && !mode_wr_req && cnt == '0) begin
                    state_d = ST_READ;
                end
            end
            ST_FLUSH: begin
                if (bm_ready) begin
                    if (final_beat) begin
                        state_d = ST_FILL;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
            end
            default: state_d = ST_READ;
        endcase
    end

    always_comb begin
        mode_wr    = (state_q != ST_READ);
        in_ready   = (state_q == ST_FILL);
        wr_en      = take;
        bm_valid   = (state_q == ST_FLUSH);
        beat_idx   = idx_q;
        beat_real  = idx_ext < cnt;
        bm_first   = bm_valid && (idx_q[BW-1:0] == '0);
        bm_last    = bm_valid && burst_end;
        drain_done = bm_valid && bm_ready && final_beat;
        clr        = drain_done;
    end

    // R5
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_last) |=> bm_valid);

    // R9
    drain_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> (state_q == ST_FILL) && (cnt == '0));

endmodule

// File: rtl/bmwb_hold.sv
module bmwb_hold #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_done,
    input  logic          dev_irq,
    input  logic [CW-1:0] cnt,
    input  logic          drain_done,
    input  logic          tgt_cyc,
    input  logic          tgt_memrd,
    output logic          tgt_retry
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (drain_done) begin
            hold_q <= 1'b0;
        end else if ((xfer_done || dev_irq) && cnt != '0) begin
            hold_q <= 1'b1;
        end
    end

    assign tgt_retry = hold_q && tgt_cyc && !tgt_memrd;

    // R7
    retry_memrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_retry |-> !tgt_memrd);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> !hold_q);

    // R8
    hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_q && cnt == '0) |=> !hold_q);

endmodule

// File: rtl/bmw_line_buffer.sv
module bmw_line_buffer #(
    parameter int DW          = 32,
    parameter int LINE_WORDS  = 8,
    parameter int BURST_WORDS = 4,
    localparam int BE         = DW / 8,
    localparam int IW         = $clog2(LINE_WORDS),
    localparam int CW         = $clog2(LINE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_req_i,
    output logic          mode_wr_o,
    input  logic          in_valid_i,
    input  logic [DW-1:0] in_data_i,
    input  logic          in_last_i,
    output logic          in_ready_o,
    output logic          bm_valid_o,
    output logic [DW-1:0] bm_data_o,
    output logic [BE-1:0] bm_cbe_n_o,
    output logic          bm_first_o,
    output logic          bm_last_o,
    input  logic          bm_ready_i,
    input  logic          xfer_done_i,
    input  logic          dev_irq_i,
    input  logic          tgt_cyc_i,
    input  logic          tgt_memrd_i,
    output logic          tgt_retry_o
);

    logic [CW-1:0] cnt;
    logic [IW-1:0] beat_idx;
    logic [DW-1:0] rd_data;
    logic          wr_en;
    logic          clr;
    logic          beat_real;
    logic          drain_done;

    bmwb_store #(.DW(DW), .LINE_WORDS(LINE_WORDS)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_data_i),
        .clr     (clr),
        .rd_idx  (beat_idx),
        .cnt     (cnt),
        .rd_data (rd_data)
    );

    bmwb_ctrl #(.LINE_WORDS(LINE_WORDS), .BURST_WORDS(BURST_WORDS)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr_req (mode_wr_req_i),
        .in_valid    (in_valid_i),
        .in_last     (in_last_i),
        .cnt         (cnt),
        .bm_ready    (bm_ready_i),
        .mode_wr     (mode_wr_o),
        .in_ready    (in_ready_o),
        .wr_en       (wr_en),
        .clr         (clr),
        .beat_idx    (beat_idx),
        .beat_real   (beat_real),
        .bm_valid    (bm_valid_o),
        .bm_first    (bm_first_o),
        .bm_last     (bm_last_o),
        .drain_done  (drain_done)
    );

    bmwb_hold #(.CW(CW)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_done  (xfer_done_i),
        .dev_irq    (dev_irq_i),
        .cnt        (cnt),
        .drain_done (drain_done),
        .tgt_cyc    (tgt_cyc_i),
        .tgt_memrd  (tgt_memrd_i),
        .tgt_retry  (tgt_retry_o)
    );

    for (genvar b = 0; b < BE; b++) begin : g_lane
        assign bm_data_o[8*b +: 8] = beat_real ? rd_data[8*b +: 8] : 8'h00;
        assign bm_cbe_n_o[b]       = !beat_real;
    end

    // R2
    mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_o != $past(mode_wr_o)) |-> ($past(cnt) == '0));

    // R3
    in_ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> mode_wr_o);

    // R6
    beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_valid_o && !bm_ready_i) |=>
            (bm_valid_o && $stable(bm_data_o) && $stable(bm_cbe_n_o)));

    // R5
    cbe_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bm_valid_o |-> (bm_cbe_n_o == '0 || bm_cbe_n_o == '1));

endmodule

// File: tb/bmw_line_buffer_tb.sv
module bmw_line_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr_req = 1'b0;
    logic        mode_wr;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        bm_valid;
    logic [31:0] bm_data;
    logic [3:0]  bm_cbe_n;
    logic        bm_first;
    logic        bm_last;
    logic        bm_ready = 1'b0;
    logic        xfer_done = 1'b0;
    logic        dev_irq = 1'b0;
    logic        tgt_cyc = 1'b0;
    logic        tgt_memrd = 1'b0;
    logic        tgt_retry;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    bmw_line_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .mode_wr_req_i(mode_wr_req), .mode_wr_o(mode_wr),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last),
        .in_ready_o(in_ready),
        .bm_valid_o(bm_valid), .bm_data_o(bm_data), .bm_cbe_n_o(bm_cbe_n),
        .bm_first_o(bm_first), .bm_last_o(bm_last), .bm_ready_i(bm_ready),
        .xfer_done_i(xfer_done), .dev_irq_i(dev_irq),
        .tgt_cyc_i(tgt_cyc), .tgt_memrd_i(tgt_memrd), .tgt_retry_o(tgt_retry)
    );

    logic [31:0] cap_d  [16];
    logic [3:0]  cap_be [16];
    logic        cap_f  [16];
    logic        cap_l  [16];
    int          ncap = 0;

    always @(negedge clk) begin
        if (bm_valid && bm_ready && ncap < 16) begin
            cap_d[ncap]  <= bm_data;
            cap_be[ncap] <= bm_cbe_n;
            cap_f[ncap]  <= bm_first;
            cap_l[ncap]  <= bm_last;
            ncap         <= ncap + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_word(input logic [31:0] d, input logic last);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        tick();
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        tgt_cyc = 1'b1;
        @(negedge clk);
        chk("R1", "mode", mode_wr, 0);
        chk("R1", "in_ready", in_ready, 0);
        chk("R1", "bm_valid", bm_valid, 0);
        chk("R1", "retry", tgt_retry, 0);
        tick();
        tgt_cyc = 1'b0;
    endtask

    task automatic t_enter_write();
        mode_wr_req = 1'b1;
        tick();
        @(negedge clk);
        chk("R2", "mode after request", mode_wr, 1);
        chk("R3", "in_ready in write", in_ready, 1);
        tick();
    endtask

    task automatic t_full_line();
        bm_ready = 1'b1;
        ncap = 0;
        for (int i = 0; i < 8; i++) send_word(32'hA000_0000 + i, 1'b0);
        @(negedge clk);
        chk("R4", "flush on full", bm_valid, 1);
        chk("R3", "no intake in flush", in_ready, 0);
        wait_cycles(10);
        @(negedge clk);
        chk("R4", "beat count", ncap, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R4", "data", cap_d[i], 32'hA000_0000 + i);
            chk("R4", "cbe", cap_be[i], 4'h0);
            chk("R4", "first", cap_f[i], (i % 4) == 0);
            chk("R4", "last", cap_l[i], (i % 4) == 3);
        end
        chk("R9", "in_ready back", in_ready, 1);
        chk("R9", "idle bus", bm_valid, 0);
    endtask

    task automatic t_partial();
        bm_ready = 1'b1;
        ncap = 0;
        for (int i = 0; i < 5; i++) send_word(32'hB000_0010 + i, i == 4);
        @(negedge clk);
        chk("R5", "flush after last", bm_valid, 1);
        wait_cycles(10);
        @(negedge clk);
        chk("R5", "rounded beats", ncap, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R5", "data", cap_d[i], (i < 5) ? 32'hB000_0010 + i : 32'h0);
            chk("R5", "cbe", cap_be[i], (i < 5) ? 4'h0 : 4'hF);
        end
        chk("R5", "last on beat 7", cap_l[7], 1);
    endtask

    task automatic t_stall();
        logic [31:0] d0;
        bm_ready = 1'b0;
        ncap = 0;
        for (int i = 0; i < 3; i++) send_word(32'hC000_0100 + i, i == 2);
        @(negedge clk);
        d0 = bm_data;
        chk("R6", "first beat data", d0, 32'hC000_0100);
        wait_cycles(3);
        @(negedge clk);
        chk("R6", "held valid", bm_valid, 1);
        chk("R6", "held data", bm_data, d0);
        tick();
        bm_ready = 1'b1;
        wait_cycles(6);
        @(negedge clk);
        chk("R6", "beats after stall", ncap, 4);
        chk("R5", "pad beat 3", cap_be[3], 4'hF);
        chk("R6", "beat 2 data", cap_d[2], 32'hC000_0102);
    endtask

    task automatic t_retry();
        bm_ready = 1'b0;
        send_word(32'hD000_0000, 1'b0);
        send_word(32'hD000_0001, 1'b0);
        tgt_cyc = 1'b1;
        @(negedge clk);
        chk("R7", "no retry before irq", tgt_retry, 0);
        tick();
        dev_irq = 1'b1;
        tick();
        dev_irq = 1'b0;
        @(negedge clk);
        chk("R7", "retry non-memrd", tgt_retry, 1);
        tick();
        tgt_memrd = 1'b1;
        @(negedge clk);
        chk("R7", "memrd not retried", tgt_retry, 0);
        tick();
        tgt_memrd = 1'b0;
        send_word(32'hD000_0002, 1'b1);
        @(negedge clk);
        chk("R7", "retry during stalled flush", tgt_retry, 1);
        tick();
        bm_ready = 1'b1;
        wait_cycles(3);
        @(negedge clk);
        chk("R8", "retry before final beat", tgt_retry, 1);
        tick();
        @(negedge clk);
        chk("R8", "retry cleared after final beat", tgt_retry, 0);
        tick();
    endtask

    task automatic t_empty_events();
        tgt_cyc = 1'b1;
        xfer_done = 1'b1;
        dev_irq = 1'b1;
        tick();
        xfer_done = 1'b0;
        dev_irq = 1'b0;
        @(negedge clk);
        chk("R8", "no retry on empty line", tgt_retry, 0);
        tick();
        tgt_cyc = 1'b0;
    endtask

    task automatic t_done_hold();
        bm_ready = 1'b0;
        tgt_cyc = 1'b1;
        send_word(32'hE000_0000, 1'b1);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        @(negedge clk);
        chk("R7", "retry after done", tgt_retry, 1);
        tick();
        bm_ready = 1'b1;
        wait_cycles(4);
        @(negedge clk);
        chk("R8", "retry released after drain", tgt_retry, 0);
        tgt_cyc = 1'b0;
        tick();
    endtask

    task automatic t_mode_block();
        bm_ready = 1'b0;
        send_word(32'hF000_0000, 1'b0);
        send_word(32'hF000_0001, 1'b0);
        mode_wr_req = 1'b0;
        wait_cycles(3);
        @(negedge clk);
        chk("R2", "mode held with data", mode_wr, 1);
        tick();
        send_word(32'hF000_0002, 1'b1);
        bm_ready = 1'b1;
        wait_cycles(8);
        @(negedge clk);
        chk("R2", "read mode after drain", mode_wr, 0);
        chk("R3", "no intake in read", in_ready, 0);
        tick();
        mode_wr_req = 1'b1;
        tick();
        @(negedge clk);
        chk("R2", "write mode again", mode_wr, 1);
        tick();
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_enter_write();
        t_full_line();
        t_partial();
        t_stall();
        t_retry();
        t_empty_events();
        t_done_hold();
        t_mode_block();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule